// File: doc/BRIEF.md
# Task-Switch Segment Reload Sequencer

This block performs the segment-register reload stage of a hardware task switch. When a switch is started, it captures six selectors from the incoming task image. It commits every one of them into the segment registers, one per cycle, in the order code, stack, data, extra, F and G. Only once all six are loaded does it validate them, again one per cycle and in the same order. The verdict for each selector comes from an external checker through a per-selector flag. The first selector that fails stops the validation. The remaining check slots still elapse, but the selectors in them are not verified, so the latency of a committed switch is always the same.

The caller may also report that the task image itself is unusable (`image_ok` low when the switch starts). In that case the fault lies before the commit point. The sequencer then leaves the segment registers untouched and reports the pointer of the instruction that started the switch. A fault found after the commit point reports the entry pointer of the new task. So does a clean switch: the code selector just loaded plus the entry offset. Each switch ends with a one-cycle `done` pulse, accompanied by `fault` when a fault was found, and with a 32-bit error code that carries the failing selector's index and an external-event flag.

Controller states and transitions: `ST_IDLE` moves on an accepted start to `ST_LOAD` (image usable) or to `ST_PREFAULT` (image unusable). `ST_LOAD` walks indices 0..5 and then moves to `ST_CHECK`. `ST_CHECK` walks indices 0..5 and then returns to `ST_IDLE`. `ST_PREFAULT` returns to `ST_IDLE` after one cycle.

Top module: `segload_seq`

## Requirements
- R1: After reset, `seg_regs`, `seg_verified`, `err_code`, `ret_sel` and `ret_off` are zero, and `busy`, `done` and `fault` are low.
- R2: A start with `image_ok` high loads selector i (field `new_sels[16i+15:16i]`, where i=0 is code, 1 stack, 2 data, 3 extra, 4 F, 5 G) into `seg_regs[16i+15:16i]` at clock edge i+1 after the start edge, so all six are loaded before the first check.
- R3: Checks run in index order 0..5, one per cycle, at edges 7..12 after the start edge. Check i reads `sel_ok[i]` and, when it passes, sets `seg_verified[i]`. After the first failure no further selector is verified, and the error code refers to that first failing index.
- R4: A committed switch raises `done` exactly 12 edges after the start edge, fault or not. At that point all six new selectors are in `seg_regs`, and `fault` is high if any check failed.
- R5: The error code is `{16'h0, sel[15:3], 2'b00, ext}`, where sel is the offending selector and ext is `ext_event` as sampled at the start. With no fault, the error code is zero.
- R6: A start with `image_ok` low is a pre-commit fault. `done` and `fault` rise one edge after the start edge. `seg_regs` and `seg_verified` stay unchanged, and the error code is formed from `image_sel`.
- R7: The return pointer is `cur_code_sel`/`cur_instr_off` (as sampled at the start) for a pre-commit fault. Otherwise it is the newly loaded code selector and `new_entry_off`.
- R8: A start while `busy` is high is ignored. The running switch keeps its captured selectors and produces exactly one `done`.
- R9: `done` is a single-cycle pulse and `fault` is only ever high together with `done`.
- R10: `busy` is high from the edge that accepts a start up to the edge that raises `done`, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a switch when idle |
| image_ok | input | 1 | Task image usable (low gives a pre-commit fault) |
| ext_event | input | 1 | Switch caused by an event external to the running program |
| image_sel | input | 16 | Selector naming the incoming task image |
| new_sels | input | 96 | Six incoming selectors, index i in bits 16i+15:16i |
| new_entry_off | input | 32 | First-instruction offset of the new task |
| cur_code_sel | input | 16 | Code selector of the instruction starting the switch |
| cur_instr_off | input | 32 | Offset of the instruction starting the switch |
| sel_ok | input | 6 | Per-selector validity verdict from the checker |
| busy | output | 1 | Switch in progress |
| done | output | 1 | One-cycle end-of-switch pulse |
| fault | output | 1 | Fault found; only with done |
| err_code | output | 32 | Error code of the last switch |
| ret_sel | output | 16 | Reported return code selector |
| ret_off | output | 32 | Reported return offset |
| seg_regs | output | 96 | Segment registers, index i in bits 16i+15:16i |
| seg_verified | output | 6 | Per-register passed-check flags |

## Verification
On every cycle, the embedded properties check several things. Each segment register changes only in its own load slot and there takes the captured selector. The load walk advances one index per cycle, which also shows that a start arriving mid-switch cannot restart it. No register is verified once a failure is recorded, `fault` never appears without `done`, and `done` lasts one cycle. The bench's scenarios are needed for the things a single-cycle view cannot show. These are the exact 12-edge and 1-edge latencies and which index the error code names when several selectors fail. They also cover the choice between old and new return pointers, and the pre-commit case leaving the registers untouched.

// File: rtl/segload_pkg.sv
package segload_pkg;

    localparam int ERR_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_LOAD     = 2'd1,
        ST_CHECK    = 2'd2,
        ST_PREFAULT = 2'd3
    } seq_state_e;

endpackage

// File: rtl/segload_ctrl.sv
module segload_ctrl
    import segload_pkg::*;
#(
    parameter int NSEG = 6,
    parameter int IDXW = $clog2(NSEG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            image_ok,
    output seq_state_e      state,
    output logic [IDXW-1:0] idx,
    output logic            accept,
    output logic            load_en,
    output logic            check_en,
    output logic            finish,
    output logic            pre_fault,
    output logic            busy
);

    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NSEG - 1);

    seq_state_e      state_d;
    logic [IDXW-1:0] idx_d;

    // next-state decision
    always_comb begin
        state_d = state;
        idx_d   = idx;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    idx_d   = '0;
                    state_d = image_ok ? ST_LOAD : ST_PREFAULT;
                end
            end
            ST_LOAD: begin
                if (idx == LAST_IDX) begin
                    state_d = ST_CHECK;
                    idx_d   = '0;
                end else begin
                    idx_d = idx + 1'b1;
                end
            end
            ST_CHECK: begin
                if (idx == LAST_IDX) begin
                    state_d = ST_IDLE;
                    idx_d   = '0;
                end else begin
                    idx_d = idx + 1'b1;
                end
            end
            ST_PREFAULT: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= state_d;
            idx   <= idx_d;
        end
    end

    // decoded controls
    always_comb begin
        accept    = (state == ST_IDLE) && start;
        load_en   = (state == ST_LOAD);
        check_en  = (state == ST_CHECK);
        pre_fault = (state == ST_PREFAULT);
        finish    = pre_fault || (check_en && (idx == LAST_IDX));
        busy      = (state != ST_IDLE);
    end

    // R8: once loading, the walk advances by one each cycle whatever start does
    a_r8_load_walk_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && idx != LAST_IDX) |=>
            (state == ST_LOAD && idx == $past(idx) + IDXW'(1)));

    // R2: all loads complete before the first check slot
    a_r2_check_after_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && idx == LAST_IDX) |=> (state == ST_CHECK && idx == '0));

    // R10: busy persists until the finishing slot
    a_r10_busy_until_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> busy);

    // R6: the pre-commit path lasts one cycle
    a_r6_prefault_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PREFAULT) |=> (state == ST_IDLE));

endmodule

// File: rtl/segload_segfile.sv
module segload_segfile #(
    parameter int NSEG = 6,
    parameter int SELW = 16,
    parameter int IDXW = $clog2(NSEG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 capture,
    input  logic                 commit_clear,
    input  logic [NSEG*SELW-1:0] image,
    input  logic                 load_en,
    input  logic                 check_en,
    input  logic [IDXW-1:0]      idx,
    input  logic [NSEG-1:0]      sel_ok,
    input  logic                 halted,
    output logic [NSEG*SELW-1:0] seg_regs,
    output logic [NSEG-1:0]      verified
);

    logic [SELW-1:0] img_q [NSEG];
    logic [SELW-1:0] seg_q [NSEG];

    for (genvar gi = 0; gi < NSEG; gi++) begin : g_seg
        localparam logic [IDXW-1:0] MY_IDX = IDXW'(gi);

        // captured image slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                img_q[gi] <= '0;
            end else if (capture) begin
                img_q[gi] <= image[gi*SELW +: SELW];
            end
        end

        // architectural segment register
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                seg_q[gi] <= '0;
            end else if (load_en && (idx == MY_IDX)) begin
                seg_q[gi] <= img_q[gi];
            end
        end

        // passed-check flag; never set once a failure is recorded
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                verified[gi] <= 1'b0;
            end else if (commit_clear) begin
                verified[gi] <= 1'b0;
            end else if (check_en && (idx == MY_IDX) && !halted && sel_ok[gi]) begin
                verified[gi] <= 1'b1;
            end
        end

        assign seg_regs[gi*SELW +: SELW] = seg_q[gi];

        // R2: a load slot writes the captured selector
        a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
            (load_en && idx == MY_IDX) |=> (seg_q[gi] == $past(img_q[gi])));

        // R6: outside its own load slot a register never changes
        a_r6_hold_outside_load: assert property (@(posedge clk) disable iff (!rst_n)
            !(load_en && idx == MY_IDX) |=> $stable(seg_q[gi]));
    end

    // R3: after the first failure nothing more gets verified
    a_r3_no_verify_after_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !commit_clear) |=> $stable(verified));

endmodule

// File: rtl/segload_fault.sv
module segload_fault
    import segload_pkg::*;
#(
    parameter int NSEG = 6,
    parameter int SELW = 16,
    parameter int OFFW = 32,
    parameter int IDXW = $clog2(NSEG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic                 ext_event,
    input  logic [SELW-1:0]      image_sel,
    input  logic [SELW-1:0]      cur_code_sel,
    input  logic [OFFW-1:0]      cur_instr_off,
    input  logic [OFFW-1:0]      new_entry_off,
    input  logic                 check_en,
    input  logic                 finish,
    input  logic                 pre_fault,
    input  logic [IDXW-1:0]      idx,
    input  logic [NSEG-1:0]      sel_ok,
    input  logic [NSEG*SELW-1:0] seg_regs,
    output logic                 halted,
    output logic                 done,
    output logic                 fault,
    output logic [ERR_W-1:0]     err_code,
    output logic [SELW-1:0]      ret_sel,
    output logic [OFFW-1:0]      ret_off
);

    logic [SELW-1:0] seg_a [NSEG];
    for (genvar gi = 0; gi < NSEG; gi++) begin : g_unpack
        assign seg_a[gi] = seg_regs[gi*SELW +: SELW];
    end

    function automatic logic [ERR_W-1:0] form_err(input logic [SELW-1:0] sel,
                                                   input logic ext);
        return ERR_W'({sel[SELW-1:3], 2'b00, ext});
    endfunction

    logic            ext_q;
    logic [SELW-1:0] img_sel_q;
    logic [SELW-1:0] cur_sel_q;
    logic [OFFW-1:0] cur_off_q;
    logic [OFFW-1:0] new_off_q;
    logic [IDXW-1:0] fail_idx_q;
    logic            fail_now;
    logic            any_fail;
    logic [ERR_W-1:0] err_d;

    // switch context captured at the accepting edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q     <= 1'b0;
            img_sel_q <= '0;
            cur_sel_q <= '0;
            cur_off_q <= '0;
            new_off_q <= '0;
        end else if (accept) begin
            ext_q     <= ext_event;
            img_sel_q <= image_sel;
            cur_sel_q <= cur_code_sel;
            cur_off_q <= cur_instr_off;
            new_off_q <= new_entry_off;
        end
    end

    always_comb begin
        fail_now = check_en && !halted && !sel_ok[idx];
        any_fail = halted || fail_now;
        if (pre_fault) begin
            err_d = form_err(img_sel_q, ext_q);
        end else if (fail_now) begin
            err_d = form_err(seg_a[idx], ext_q);
        end else if (halted) begin
            err_d = form_err(seg_a[fail_idx_q], ext_q);
        end else begin
            err_d = '0;
        end
    end

    // first-failure record
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halted     <= 1'b0;
            fail_idx_q <= '0;
        end else if (accept) begin
            halted     <= 1'b0;
            fail_idx_q <= '0;
        end else if (fail_now) begin
            halted     <= 1'b1;
            fail_idx_q <= idx;
        end
    end

    // completion outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done     <= 1'b0;
            fault    <= 1'b0;
            err_code <= '0;
            ret_sel  <= '0;
            ret_off  <= '0;
        end else begin
            done  <= finish;
            fault <= finish && (pre_fault || any_fail);
            if (finish) begin
                err_code <= err_d;
                if (pre_fault) begin
                    ret_sel <= cur_sel_q;
                    ret_off <= cur_off_q;
                end else begin
                    ret_sel <= seg_a[0];
                    ret_off <= new_off_q;
                end
            end
        end
    end

    // R9: fault only accompanies done
    a_r9_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done);

    // R9: done is a single-cycle pulse
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: the first failing index is kept for the rest of the checks
    a_r3_first_fail_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !accept) |=> (halted && $stable(fail_idx_q)));

    // R5: a clean switch reports a zero error code
    a_r5_clean_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> (err_code == '0));

endmodule

// File: rtl/segload_seq.sv
module segload_seq
    import segload_pkg::*;
#(
    parameter int NSEG = 6,
    parameter int SELW = 16,
    parameter int OFFW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 image_ok,
    input  logic                 ext_event,
    input  logic [SELW-1:0]      image_sel,
    input  logic [NSEG*SELW-1:0] new_sels,
    input  logic [OFFW-1:0]      new_entry_off,
    input  logic [SELW-1:0]      cur_code_sel,
    input  logic [OFFW-1:0]      cur_instr_off,
    input  logic [NSEG-1:0]      sel_ok,
    output logic                 busy,
    output logic                 done,
    output logic                 fault,
    output logic [ERR_W-1:0]     err_code,
    output logic [SELW-1:0]      ret_sel,
    output logic [OFFW-1:0]      ret_off,
    output logic [NSEG*SELW-1:0] seg_regs,
    output logic [NSEG-1:0]      seg_verified
);

    localparam int IDXW = $clog2(NSEG);

    seq_state_e      state;
    logic [IDXW-1:0] idx;
    logic            accept;
    logic            load_en;
    logic            check_en;
    logic            finish;
    logic            pre_fault;
    logic            halted;
    logic            commit_clear;

    assign commit_clear = accept && image_ok;

    segload_ctrl #(.NSEG(NSEG), .IDXW(IDXW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .image_ok  (image_ok),
        .state     (state),
        .idx       (idx),
        .accept    (accept),
        .load_en   (load_en),
        .check_en  (check_en),
        .finish    (finish),
        .pre_fault (pre_fault),
        .busy      (busy)
    );

    segload_segfile #(.NSEG(NSEG), .SELW(SELW), .IDXW(IDXW)) u_segfile (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture      (accept),
        .commit_clear (commit_clear),
        .image        (new_sels),
        .load_en      (load_en),
        .check_en     (check_en),
        .idx          (idx),
        .sel_ok       (sel_ok),
        .halted       (halted),
        .seg_regs     (seg_regs),
        .verified     (seg_verified)
    );

    segload_fault #(.NSEG(NSEG), .SELW(SELW), .OFFW(OFFW), .IDXW(IDXW)) u_fault (
        .clk           (clk),
        .rst_n         (rst_n),
        .accept        (accept),
        .ext_event     (ext_event),
        .image_sel     (image_sel),
        .cur_code_sel  (cur_code_sel),
        .cur_instr_off (cur_instr_off),
        .new_entry_off (new_entry_off),
        .check_en      (check_en),
        .finish        (finish),
        .pre_fault     (pre_fault),
        .idx           (idx),
        .sel_ok        (sel_ok),
        .seg_regs      (seg_regs),
        .halted        (halted),
        .done          (done),
        .fault         (fault),
        .err_code      (err_code),
        .ret_sel       (ret_sel),
        .ret_off       (ret_off)
    );

    // R10: done arrives with the sequencer already idle
    a_r10_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/test_segload_seq.sv
module test_segload_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        image_ok = 1'b1;
    logic        ext_event = 1'b0;
    logic [15:0] image_sel = '0;
    logic [95:0] new_sels = '0;
    logic [31:0] new_entry_off = '0;
    logic [15:0] cur_code_sel = '0;
    logic [31:0] cur_instr_off = '0;
    logic [5:0]  sel_ok = '1;
    logic        busy, done, fault;
    logic [31:0] err_code;
    logic [15:0] ret_sel;
    logic [31:0] ret_off;
    logic [95:0] seg_regs;
    logic [5:0]  seg_verified;

    int n_chk = 0;
    int n_fail = 0;

    logic [95:0] exp_segs = '0;
    logic [5:0]  exp_ver = '0;

    always #4 clk = ~clk;

    segload_seq i_segload_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .image_ok(image_ok),
        .ext_event(ext_event), .image_sel(image_sel), .new_sels(new_sels),
        .new_entry_off(new_entry_off), .cur_code_sel(cur_code_sel),
        .cur_instr_off(cur_instr_off), .sel_ok(sel_ok), .busy(busy),
        .done(done), .fault(fault), .err_code(err_code), .ret_sel(ret_sel),
        .ret_off(ret_off), .seg_regs(seg_regs), .seg_verified(seg_verified)
    );

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [95:0] mk_image(input logic [15:0] base);
        logic [95:0] v;
        for (int i = 0; i < 6; i++) v[16*i +: 16] = base + 16'(i * 8) + 16'(i);
        return v;
    endfunction

    function automatic logic [31:0] mk_err(input logic [15:0] s, input logic e);
        return {16'h0, s[15:3], 2'b00, e};
    endfunction

    task automatic t_reset();
        chk("R1 seg_regs", seg_regs, '0);
        chk("R1 seg_verified", 96'(seg_verified), '0);
        chk("R1 busy/done/fault", {busy, done, fault}, '0);
        chk("R1 err_code", 96'(err_code), '0);
        chk("R1 ret", {ret_sel, ret_off}, '0);
    endtask

    // committed switch; intrude drives a second start while busy
    task automatic t_commit(input logic [15:0] base, input logic [5:0] ok,
                            input logic ext, input bit intrude);
        logic [95:0] img;
        logic [95:0] old;
        int   first;
        logic [31:0] exp_err;
        img   = mk_image(base);
        old   = exp_segs;
        first = -1;
        for (int i = 5; i >= 0; i--) if (!ok[i]) first = i;
        @(negedge clk);
        new_sels = img; image_ok = 1'b1; ext_event = ext; sel_ok = ok;
        new_entry_off = {16'hE000, base}; cur_code_sel = 16'h0123;
        cur_instr_off = 32'h0000_4444; image_sel = base ^ 16'hFF00;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 busy after accept", 96'(busy), 96'(1));
        for (int e = 1; e <= 11; e++) begin
            start = intrude && (e == 4);
            if (intrude && e == 4) new_sels = mk_image(16'h7770);
            @(negedge clk);
            if (e == 3) begin
                chk("R2 partial load order", seg_regs, {old[95:48], img[47:0]});
            end
        end
        start = 1'b0;
        chk("R4 no done before edge 12", 96'({done, busy}), 96'(2'b01));
        @(negedge clk);
        exp_segs = img;
        exp_ver  = (first < 0) ? 6'h3F : 6'((1 << first) - 1);
        exp_err  = (first < 0) ? 32'h0 : mk_err(img[16*first +: 16], ext);
        chk("R4 done at edge 12", 96'({done, fault, busy}), 96'({1'b1, first >= 0, 1'b0}));
        chk("R4 all selectors loaded", seg_regs, img);
        chk("R5 error code", 96'(err_code), 96'(exp_err));
        chk("R3 verified flags", 96'(seg_verified), 96'(exp_ver));
        chk("R7 new-task return pointer", {ret_sel, ret_off}, {img[15:0], 16'hE000, base});
        @(negedge clk);
        chk("R9 done single pulse", 96'({done, fault}), '0);
        if (intrude) begin
            for (int e = 0; e < 14; e++) begin
                chk("R8 no second done/busy", 96'({done, busy}), '0);
                @(negedge clk);
            end
        end
    endtask

    task automatic t_precommit(input logic [15:0] isel, input logic ext);
        @(negedge clk);
        new_sels = mk_image(16'h3330); image_ok = 1'b0; ext_event = ext;
        sel_ok = '1; image_sel = isel; cur_code_sel = 16'h0BAD;
        cur_instr_off = 32'h0000_9876; new_entry_off = 32'h1111_2222;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        image_ok = 1'b1;
        chk("R6 busy, not done yet", 96'({busy, done}), 96'(2'b10));
        @(negedge clk);
        chk("R6 done+fault after one edge", 96'({done, fault, busy}), 96'(3'b110));
        chk("R6 registers untouched", seg_regs, exp_segs);
        chk("R6 verified untouched", 96'(seg_verified), 96'(exp_ver));
        chk("R5 pre-commit error code", 96'(err_code), 96'(mk_err(isel, ext)));
        chk("R7 old return pointer", {ret_sel, ret_off}, {16'h0BAD, 32'h0000_9876});
        for (int e = 0; e < 13; e++) begin
            @(negedge clk);
            chk("R6 no loads after pre-commit fault", seg_regs, exp_segs);
        end
    endtask

    initial begin
        #(200000 * 8);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_commit(16'h0040, 6'b111111, 1'b0, 1'b0);   // clean switch
        t_commit(16'h0100, 6'b111110, 1'b1, 1'b0);   // R3 code selector fails
        t_commit(16'h0200, 6'b011011, 1'b0, 1'b0);   // R3 data fails first, G also bad
        t_commit(16'h0300, 6'b011111, 1'b1, 1'b0);   // R3 only last fails
        t_precommit(16'hA5A8, 1'b1);                 // R6 image unusable
        t_commit(16'h0400, 6'b111111, 1'b0, 1'b1);   // R8 start while busy
        t_precommit(16'h1230, 1'b0);
        t_commit(16'h0500, 6'b110111, 1'b1, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule